// File: doc/BRIEF.md
# Oscillator Frequency Lock Detector

This block judges whether a recovered-clock oscillator runs close enough to its nominal rate, which is a fixed multiple (20 by default) of a slower reference clock. It counts oscillator cycles across a gate made of a power-of-two number of reference cycles. It compares the count with the nominal value and tests the difference against one of two tolerance windows, chosen by a single input.

The result drives two outputs. A path select steers loop control to the reference phase-frequency comparator while the oscillator is being pulled in, and to the data phase detector once the frequency is inside the window. A lock flag reports the settled state. Monitoring never stops: every gate produces a fresh verdict, and a single bad one returns the loop to acquisition.

Top module: `freqlock_detector`

## Requirements
- R1: While `rst_n` is low, `lock` and `use_data_pd` are 0, and they stay 0 on the next clock edge after reset. The first gate after reset release gives no verdict, so both outputs stay 0 until the second gate ends.
- R2: Each measurement counts oscillator rising edges over 2^GATE_LOG2 reference cycles. The nominal count is REF_MULT x 2^GATE_LOG2 (81920 at defaults). The running count crosses into the reference domain as Gray code, which changes by one bit per oscillator cycle, through a two-flop synchronizer.
- R3: With `wide_win` = 0, a measurement is in window when |count - nominal| <= round(nominal x NARROW_PPM / 10^6). This is 41 counts at defaults.
- R4: With `wide_win` = 1, the tolerance is round(nominal x WIDE_PPM / 10^6). This is 164 counts at defaults.
- R5: `use_data_pd` = 1 selects the data phase detector and 0 selects the reference comparator. After every measurement it equals that measurement's in-window result.
- R6: `lock` rises only when two consecutive measurements are in window, and it stays high while later measurements stay in window.
- R7: One out-of-window measurement clears `lock` and `use_data_pd` in the same update.
- R8: Outputs change only on the reference edge that follows the last cycle of a gate. Gates are 2^GATE_LOG2 reference cycles long and are counted from the first edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, the domain of all decisions |
| osc_clk | input | 1 | Oscillator clock under measurement |
| rst_n | input | 1 | Active-low reset, synchronous to `ref_clk` |
| wide_win | input | 1 | 0 selects the narrow window, 1 selects the wide window; synchronous to `ref_clk` |
| lock | output | 1 | High while the oscillator is judged in lock |
| use_data_pd | output | 1 | 1 routes loop control to the data phase detector, 0 to the reference comparator |

## Verification
The gate-end edge registers a verdict, and both outputs move one reference edge later. So with gate length G, counted from reset release, results are due at edge kG+1 and nowhere else. The bench samples at falling edges one cycle before and one cycle after each such edge, so both the old value and the new value are checked. Each oscillator frequency change is made at mid-gate. The gate that straddles the change is then always out of window, because every test point is entered from a far-off frequency. A known number of clean gates follows, and the expected path and lock values come from the tolerance arithmetic. Points within two counts of a window edge are skipped, because gate quantization and synchronizer sampling can move a count by that much.

// File: rtl/freqlock_pkg.sv
// Shared definitions for the frequency lock detector.
package freqlock_pkg;

    // Loop steering encoding for the path select output.
    typedef enum logic {
        PATH_REF  = 1'b0,
        PATH_DATA = 1'b1
    } path_e;

    // Converts a ppm tolerance into a count tolerance, rounded to nearest.
    function automatic int unsigned ppm_counts(input longint unsigned nominal,
                                               input longint unsigned ppm);
        longint unsigned scaled;
        scaled = (nominal * ppm + 64'd500000) / 64'd1000000;
        return int'(scaled);
    endfunction

endpackage

// File: rtl/osc_gray_counter.sv
// Free-running oscillator-domain counter published as registered Gray code.
// Assumes rst_n comes from the reference domain; it is resynchronized here
// and used as a synchronous reset inside the oscillator domain.
module osc_gray_counter #(
    parameter int unsigned CW = 19
) (
    input  logic          osc_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_o
);
    logic [1:0]    rst_q;
    logic          osc_rst_n;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    assign osc_rst_n = rst_q[1];
    assign bin_nx    = bin_q + CW'(1);

    // Bring the reset into the oscillator domain.
    always_ff @(posedge osc_clk) begin
        rst_q <= {rst_q[0], rst_n};
    end

    // Count oscillator cycles and register their Gray image.
    always_ff @(posedge osc_clk) begin
        if (!osc_rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // R2: the published code moves by at most one bit per oscillator cycle.
    a_r2_gray_one_bit: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/gray_sync.sv
// Two-flop synchronizer for a Gray-coded count, followed by Gray-to-binary.
// Assumes the source changes at most one bit per source cycle.
module gray_sync #(
    parameter int unsigned CW = 19
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);
    logic [CW-1:0] s1_q;
    logic [CW-1:0] s2_q;

    // Resample the Gray code twice in the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_i;
            s2_q <= s1_q;
        end
    end

    // Decode Gray to binary, most significant bit first.
    always_comb begin
        bin_o[CW-1] = s2_q[CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ s2_q[i];
        end
    end

endmodule

// File: rtl/freq_meter.sv
// Gates the synchronized oscillator count over 2^GATE_LOG2 reference cycles
// and tests the per-gate difference against the selected window.
// Assumes wide_i is synchronous to ref_clk. The first gate is discarded.
module freq_meter #(
    parameter int unsigned GATE_LOG2 = 12,
    parameter int unsigned CW        = 19,
    parameter int unsigned NOMINAL   = 81920,
    parameter int unsigned TOL_N     = 41,
    parameter int unsigned TOL_W     = 164
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          wide_i,
    output logic          meas_valid_o,
    output logic          in_win_o
);
    localparam logic [CW-1:0] LO_N = CW'(NOMINAL - TOL_N);
    localparam logic [CW-1:0] HI_N = CW'(NOMINAL + TOL_N);
    localparam logic [CW-1:0] LO_W = CW'(NOMINAL - TOL_W);
    localparam logic [CW-1:0] HI_W = CW'(NOMINAL + TOL_W);

    logic [GATE_LOG2-1:0] gate_q;
    logic                 gate_end;
    logic                 primed_q;
    logic [CW-1:0]        prev_q;
    logic [CW-1:0]        delta;
    logic [CW-1:0]        lo;
    logic [CW-1:0]        hi;

    assign gate_end = &gate_q;
    assign delta    = count_i - prev_q;
    assign lo       = wide_i ? LO_W : LO_N;
    assign hi       = wide_i ? HI_W : HI_N;

    // Advance the gate timer every reference cycle.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_q + GATE_LOG2'(1);
    end

    // At each gate end, snapshot the count and register the window verdict.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            prev_q       <= '0;
            primed_q     <= 1'b0;
            meas_valid_o <= 1'b0;
            in_win_o     <= 1'b0;
        end else if (gate_end) begin
            prev_q       <= count_i;
            primed_q     <= 1'b1;
            meas_valid_o <= primed_q;
            in_win_o     <= (delta >= lo) && (delta <= hi);
        end else begin
            meas_valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lock_ctrl.sv
// Turns per-gate verdicts into the path select and the qualified lock flag.
// Assumes meas_valid_i pulses for one cycle per completed gate.
module lock_ctrl
    import freqlock_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic meas_valid_i,
    input  logic in_win_i,
    output logic lock_o,
    output logic path_o
);
    path_e path_q;
    logic  prev_in_q;

    assign path_o = (path_q == PATH_DATA);

    // Update steering and lock on each fresh verdict.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            path_q    <= PATH_REF;
            prev_in_q <= 1'b0;
            lock_o    <= 1'b0;
        end else if (meas_valid_i) begin
            path_q    <= in_win_i ? PATH_DATA : PATH_REF;
            prev_in_q <= in_win_i;
            lock_o    <= in_win_i && prev_in_q;
        end
    end

    // R6: a locked loop always tracks with the data detector.
    a_r6_lock_on_data: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lock_o |-> path_o);

    // R6: lock rises only after the data path was already chosen.
    a_r6_rise_qualified: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(path_o));

    // R7: an out-of-window verdict drops lock and returns to acquisition.
    a_r7_drop_on_miss: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_valid_i && !in_win_i) |=> (!lock_o && !path_o));

    // R8: outputs hold between verdicts.
    a_r8_hold_between: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(meas_valid_i)) |-> ($stable(lock_o) && $stable(path_o)));

endmodule

// File: rtl/freqlock_detector.sv
// Top of the frequency lock detector: oscillator-domain counter, Gray
// crossing, gated meter and lock control. Assumes rst_n and wide_win are
// synchronous to ref_clk and osc_clk is nominally REF_MULT times ref_clk.
module freqlock_detector #(
    parameter int unsigned REF_MULT   = 20,
    parameter int unsigned GATE_LOG2  = 12,
    parameter int unsigned NARROW_PPM = 500,
    parameter int unsigned WIDE_PPM   = 2000
) (
    input  logic ref_clk,
    input  logic osc_clk,
    input  logic rst_n,
    input  logic wide_win,
    output logic lock,
    output logic use_data_pd
);
    import freqlock_pkg::*;

    localparam int unsigned NOMINAL = REF_MULT << GATE_LOG2;
    localparam int unsigned CW      = $clog2(NOMINAL) + 2;
    localparam int unsigned TOL_N   = ppm_counts(NOMINAL, NARROW_PPM);
    localparam int unsigned TOL_W   = ppm_counts(NOMINAL, WIDE_PPM);

    logic [CW-1:0] gray;
    logic [CW-1:0] count;
    logic          meas_valid;
    logic          in_win;

    osc_gray_counter #(.CW(CW)) u_cnt (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .gray_o  (gray)
    );

    gray_sync #(.CW(CW)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (gray),
        .bin_o   (count)
    );

    freq_meter #(
        .GATE_LOG2 (GATE_LOG2),
        .CW        (CW),
        .NOMINAL   (NOMINAL),
        .TOL_N     (TOL_N),
        .TOL_W     (TOL_W)
    ) u_meter (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .count_i      (count),
        .wide_i       (wide_win),
        .meas_valid_o (meas_valid),
        .in_win_o     (in_win)
    );

    lock_ctrl u_lock (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .meas_valid_i (meas_valid),
        .in_win_i     (in_win),
        .lock_o       (lock),
        .path_o       (use_data_pd)
    );

endmodule

// File: tb/freqlock_detector_bench.sv
`timescale 1ns/1fs
module freqlock_detector_bench;
    localparam int G       = 64;
    localparam int GL2     = 6;
    localparam int MULT    = 20;
    localparam int NPPM    = 5000;
    localparam int WPPM    = 20000;
    localparam int NOM     = MULT * G;
    localparam int TN      = (NOM * NPPM + 500000) / 1000000;
    localparam int TW      = (NOM * WPPM + 500000) / 1000000;
    localparam int FAR     = 140;

    logic ref_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic wide_win = 1'b0;
    logic lock;
    logic use_data_pd;

    real half_ns = 0.125;
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    freqlock_detector #(
        .REF_MULT(MULT), .GATE_LOG2(GL2), .NARROW_PPM(NPPM), .WIDE_PPM(WPPM)
    ) u_freqlock_detector (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .wide_win(wide_win), .lock(lock), .use_data_pd(use_data_pd)
    );

    always #2.5 ref_clk = ~ref_clk;
    always begin
        #(half_ns);
        osc_clk = ~osc_clk;
    end
    always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

    task automatic set_dev(input int d);
        half_ns = (G * 5.0) / (2.0 * (NOM + d));
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    // Enter at mid-gate from a far-off state; ends at mid-gate again.
    task automatic run_point(input int d, input bit wide);
        int tol;
        bit exp_in;
        tol = wide ? TW : TN;
        exp_in = ((d < 0) ? -d : d) <= tol;
        set_dev(d);
        step(3 * G / 2);
        chk("R8 path before boundary", use_data_pd, 1'b0);
        step(1);
        chk(wide ? "R4/R5 path after clean gate" : "R3/R5 path after clean gate", use_data_pd, exp_in);
        chk("R6 no lock after one gate", lock, 1'b0);
        step(G);
        chk(wide ? "R2/R4/R6 lock" : "R2/R3/R6 lock", lock, exp_in);
        step(G / 2 - 1);
        set_dev(FAR);
        step(3 * G / 2 + 1);
        chk("R7 lock cleared", lock, 1'b0);
        chk("R7 path to reference", use_data_pd, 1'b0);
        step(G / 2 - 1);
    endtask

    initial begin
        set_dev(0);
        step(6);
        chk("R1 reset lock", lock, 1'b0);
        chk("R1 reset path", use_data_pd, 1'b0);
        rst_n = 1'b1;
        step(G + 1);
        chk("R1 first gate discarded lock", lock, 1'b0);
        chk("R1 first gate discarded path", use_data_pd, 1'b0);
        step(G);
        chk("R5 path after first verdict", use_data_pd, 1'b1);
        chk("R6 lock waits for second", lock, 1'b0);
        step(G);
        chk("R6 lock after two", lock, 1'b1);
        step(G / 2 - 1);
        set_dev(FAR);
        step(3 * G / 2 + 1);
        chk("R7 far clears lock", lock, 1'b0);
        step(G / 2 - 1);
        for (int w = 0; w < 2; w++) begin
            wide_win = (w != 0);
            for (int d = -34; d <= 34; d += 2) begin
                int tol;
                int a;
                tol = (w != 0) ? TW : TN;
                a = (d < 0) ? -d : d;
                if (a >= tol - 2 && a <= tol + 2) continue;
                run_point(d, w != 0);
            end
        end
        set_dev(0);
        step(5 * G / 2 + 1);
        chk("R6 relock", lock, 1'b1);
        rst_n = 1'b0;
        step(1);
        chk("R1 mid-run reset lock", lock, 1'b0);
        chk("R1 mid-run reset path", use_data_pd, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule